// File: doc/BRIEF.md
# Safe Load-Data Forwarding Gate

This block stands between load completion and the wakeup of instructions that depend on a load. Each load is tracked by its reorder-buffer (ROB) index from allocation until it forwards or is flushed. When a load's data returns, the block holds back its wakeup until a safety condition holds. It then raises that load's forward-enable bit for a single cycle. Data values and rename state never enter the block; it handles only indices and status bits.

Two policies are selectable on every cycle. The at-head policy releases a load only when its ROB index equals the head pointer. The early policy releases a load once every older ROB entry is free of unresolved control flow and unknown memory addresses. To support that, the block keeps two pending bits per ROB entry: "branch unresolved" and "address not yet generated". A misprediction or exception at some index discards every younger tracked load and every younger pending bit. Age is always measured from the current head, so the ROB wraps freely.

Top module: `safe_fwd_gate`

## Requirements
- R1: While reset is active, and until the first event after reset, every bit of `fwd_en_o` is 0.
- R2: With `mode_i` = 0 (at-head policy), a completed load forwards only while its index equals `rob_head_i`.
- R3: With `mode_i` = 1 (early policy), a completed load is held while any older entry allocated with `alloc_br_i` = 1 has not yet been resolved on the `br_res` port.
- R4: With `mode_i` = 1, a completed load is held while any older entry allocated with `alloc_mem_i` = 1 or `alloc_ld_i` = 1 has no address reported on the `agen` port. It is released as soon as the last such entry reports.
- R5: A flush at index F permanently cancels every tracked load whose age (index minus head, modulo depth) exceeds F's age. A later completion at that index does not make it forward.
- R6: `fwd_en_o[i]` goes high for exactly one cycle, once per tracked load. The pulse appears in the cycle after the first clock edge at which the load is tracked, has completed, and meets the policy with the current head and mode.
- R7: Age comparison wraps modulo the ROB depth. For example, with head 14, entries 15 and 0 are younger than 14, and 0 is younger than 15.
- R8: A completion reported for an index that holds no tracked load produces no forward-enable.
- R9: The flushing index itself is not cancelled; a load at F still forwards once safe.
- R10: The policy is re-evaluated every cycle. A completed load held under the at-head policy forwards in the cycle after `mode_i` switches to 1, if the early condition holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 1 | 0 = at-head policy, 1 = early policy |
| rob_head_i | input | IDX_W | Current ROB head index |
| alloc_valid_i | input | 1 | An ROB entry is allocated this cycle |
| alloc_idx_i | input | IDX_W | Index being allocated |
| alloc_br_i | input | 1 | Allocated entry is a branch (branch-pending set) |
| alloc_mem_i | input | 1 | Allocated entry is a memory operation (address-pending set) |
| alloc_ld_i | input | 1 | Allocated entry is a load to track (address-pending also set) |
| br_res_valid_i | input | 1 | A branch resolved this cycle |
| br_res_idx_i | input | IDX_W | Index of the resolved branch |
| agen_valid_i | input | 1 | A memory operation produced its address |
| agen_idx_i | input | IDX_W | Index whose address is known |
| ld_done_valid_i | input | 1 | Load data has returned |
| ld_done_idx_i | input | IDX_W | Index of the completed load |
| flush_valid_i | input | 1 | Misprediction or exception flush |
| flush_idx_i | input | IDX_W | Index of the faulting entry; younger entries are discarded |
| fwd_en_o | output | ROB_DEPTH | Per-index one-cycle forward-enable |

## Verification
A corrupted tracked, completed or pending bit shows up directly at `fwd_en_o`. Depending on the fault, a load pulses too early, pulses twice, pulses after being flushed, or never pulses. Every such error is visible one cycle after the clock edge that should have decided the load's release. A wrong age computation shows up mainly at the wrap of the head pointer and at flush boundaries, so those cases are driven deliberately, alongside random traffic compared cycle by cycle against an expected model.

// File: rtl/safe_fwd_pkg.sv
package safe_fwd_pkg;

  typedef enum logic {
    MODE_AT_HEAD = 1'b0,
    MODE_EARLY   = 1'b1
  } fwd_mode_e;

  // Distance of an index from the head, modulo a power-of-two depth.
  function automatic int unsigned age_from_head(input int unsigned idx,
                                                input int unsigned head,
                                                input int unsigned depth);
    return (idx + depth - head) & (depth - 1);
  endfunction

endpackage

// File: rtl/safe_fwd_rst_sync.sv
module safe_fwd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_sync = out_q;

endmodule

// File: rtl/safe_fwd_pending.sv
module safe_fwd_pending #(
  parameter int ROB_DEPTH = 16,
  parameter int IDX_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 alloc_valid_i,
  input  logic [IDX_W-1:0]     alloc_idx_i,
  input  logic                 alloc_br_i,
  input  logic                 alloc_addr_i,
  input  logic                 br_res_valid_i,
  input  logic [IDX_W-1:0]     br_res_idx_i,
  input  logic                 agen_valid_i,
  input  logic [IDX_W-1:0]     agen_idx_i,
  input  logic [ROB_DEPTH-1:0] kill_i,
  output logic [ROB_DEPTH-1:0] blk_o
);

  for (genvar e = 0; e < ROB_DEPTH; e++) begin : g_ent
    localparam logic [IDX_W-1:0] EIDX = IDX_W'(e);
    logic ctl_q, ctl_d;
    logic adr_q, adr_d;
    logic en;

    always_comb begin
      ctl_d = ctl_q;
      adr_d = adr_q;
      if (alloc_valid_i && alloc_idx_i == EIDX) begin
        ctl_d = alloc_br_i;
        adr_d = alloc_addr_i;
      end
      if (br_res_valid_i && br_res_idx_i == EIDX) ctl_d = 1'b0;
      if (agen_valid_i && agen_idx_i == EIDX)     adr_d = 1'b0;
      if (kill_i[e]) begin
        ctl_d = 1'b0;
        adr_d = 1'b0;
      end
      en = (ctl_d != ctl_q) || (adr_d != adr_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctl_q <= 1'b0;
        adr_q <= 1'b0;
      end else if (en) begin
        ctl_q <= ctl_d;
        adr_q <= adr_d;
      end
    end

    assign blk_o[e] = ctl_q | adr_q;
  end

endmodule

// File: rtl/safe_fwd_age.sv
module safe_fwd_age
  import safe_fwd_pkg::*;
#(
  parameter int ROB_DEPTH = 16,
  parameter int IDX_W     = 4
) (
  input  logic [IDX_W-1:0]     head_i,
  input  logic [ROB_DEPTH-1:0] blk_i,
  input  logic                 flush_valid_i,
  input  logic [IDX_W-1:0]     flush_idx_i,
  output logic [ROB_DEPTH-1:0] at_head_o,
  output logic [ROB_DEPTH-1:0] older_clear_o,
  output logic [ROB_DEPTH-1:0] kill_o
);

  for (genvar l = 0; l < ROB_DEPTH; l++) begin : g_ld
    int unsigned my_age;
    int unsigned flush_age;
    logic        clear;

    always_comb begin
      my_age    = age_from_head(l, int'(head_i), ROB_DEPTH);
      flush_age = age_from_head(int'(flush_idx_i), int'(head_i), ROB_DEPTH);
      clear     = 1'b1;
      for (int j = 0; j < ROB_DEPTH; j++) begin
        if (blk_i[j] && age_from_head(j, int'(head_i), ROB_DEPTH) < my_age)
          clear = 1'b0;
      end
    end

    assign at_head_o[l]     = (my_age == 0);
    assign older_clear_o[l] = clear;
    assign kill_o[l]        = flush_valid_i && (my_age > flush_age);
  end

endmodule

// File: rtl/safe_fwd_track.sv
module safe_fwd_track
  import safe_fwd_pkg::*;
#(
  parameter int ROB_DEPTH = 16,
  parameter int IDX_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  fwd_mode_e            mode_i,
  input  logic [ROB_DEPTH-1:0] at_head_i,
  input  logic [ROB_DEPTH-1:0] older_clear_i,
  input  logic [ROB_DEPTH-1:0] kill_i,
  input  logic                 alloc_valid_i,
  input  logic [IDX_W-1:0]     alloc_idx_i,
  input  logic                 alloc_ld_i,
  input  logic                 done_valid_i,
  input  logic [IDX_W-1:0]     done_idx_i,
  output logic [ROB_DEPTH-1:0] fwd_en_o
);

  logic [ROB_DEPTH-1:0] trk_q, trk_d;
  logic [ROB_DEPTH-1:0] done_q, done_d;
  logic [ROB_DEPTH-1:0] safe;
  logic [ROB_DEPTH-1:0] fire;
  logic [ROB_DEPTH-1:0] fwd_q;
  logic                 state_en;

  always_comb begin
    safe = (mode_i == MODE_EARLY) ? older_clear_i : at_head_i;
    fire = trk_q & done_q & safe & ~kill_i;

    trk_d  = trk_q  & ~fire;
    done_d = done_q & ~fire;
    if (alloc_valid_i) begin
      trk_d[alloc_idx_i]  = alloc_ld_i;
      done_d[alloc_idx_i] = 1'b0;
    end
    if (done_valid_i && trk_d[done_idx_i]) done_d[done_idx_i] = 1'b1;
    trk_d  = trk_d  & ~kill_i;
    done_d = done_d & ~kill_i;

    state_en = alloc_valid_i || done_valid_i || (|kill_i) || (|fire);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trk_q  <= '0;
      done_q <= '0;
    end else if (state_en) begin
      trk_q  <= trk_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fwd_q <= '0;
    else        fwd_q <= fire;
  end

  assign fwd_en_o = fwd_q;

endmodule

// File: rtl/safe_fwd_gate.sv
module safe_fwd_gate
  import safe_fwd_pkg::*;
#(
  parameter  int ROB_DEPTH = 16,
  localparam int IDX_W     = $clog2(ROB_DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_i,
  input  logic [IDX_W-1:0]     rob_head_i,
  input  logic                 alloc_valid_i,
  input  logic [IDX_W-1:0]     alloc_idx_i,
  input  logic                 alloc_br_i,
  input  logic                 alloc_mem_i,
  input  logic                 alloc_ld_i,
  input  logic                 br_res_valid_i,
  input  logic [IDX_W-1:0]     br_res_idx_i,
  input  logic                 agen_valid_i,
  input  logic [IDX_W-1:0]     agen_idx_i,
  input  logic                 ld_done_valid_i,
  input  logic [IDX_W-1:0]     ld_done_idx_i,
  input  logic                 flush_valid_i,
  input  logic [IDX_W-1:0]     flush_idx_i,
  output logic [ROB_DEPTH-1:0] fwd_en_o
);

  logic                 rst_n_int;
  logic [ROB_DEPTH-1:0] blk;
  logic [ROB_DEPTH-1:0] at_head;
  logic [ROB_DEPTH-1:0] older_clear;
  logic [ROB_DEPTH-1:0] kill;
  fwd_mode_e            mode;

  assign mode = fwd_mode_e'(mode_i);

  safe_fwd_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  safe_fwd_age #(.ROB_DEPTH(ROB_DEPTH), .IDX_W(IDX_W)) u_age (
    .head_i        (rob_head_i),
    .blk_i         (blk),
    .flush_valid_i (flush_valid_i),
    .flush_idx_i   (flush_idx_i),
    .at_head_o     (at_head),
    .older_clear_o (older_clear),
    .kill_o        (kill)
  );

  safe_fwd_pending #(.ROB_DEPTH(ROB_DEPTH), .IDX_W(IDX_W)) u_pend (
    .clk            (clk),
    .rst_n          (rst_n_int),
    .alloc_valid_i  (alloc_valid_i),
    .alloc_idx_i    (alloc_idx_i),
    .alloc_br_i     (alloc_br_i),
    .alloc_addr_i   (alloc_mem_i | alloc_ld_i),
    .br_res_valid_i (br_res_valid_i),
    .br_res_idx_i   (br_res_idx_i),
    .agen_valid_i   (agen_valid_i),
    .agen_idx_i     (agen_idx_i),
    .kill_i         (kill),
    .blk_o          (blk)
  );

  safe_fwd_track #(.ROB_DEPTH(ROB_DEPTH), .IDX_W(IDX_W)) u_trk (
    .clk           (clk),
    .rst_n         (rst_n_int),
    .mode_i        (mode),
    .at_head_i     (at_head),
    .older_clear_i (older_clear),
    .kill_i        (kill),
    .alloc_valid_i (alloc_valid_i),
    .alloc_idx_i   (alloc_idx_i),
    .alloc_ld_i    (alloc_ld_i),
    .done_valid_i  (ld_done_valid_i),
    .done_idx_i    (ld_done_idx_i),
    .fwd_en_o      (fwd_en_o)
  );

endmodule

// File: rtl/safe_fwd_gate_chk.sv
module safe_fwd_gate_chk
  import safe_fwd_pkg::*;
#(
  parameter int ROB_DEPTH = 16,
  parameter int IDX_W     = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 mode_i,
  input logic [IDX_W-1:0]     rob_head_i,
  input logic                 alloc_valid_i,
  input logic [IDX_W-1:0]     alloc_idx_i,
  input logic                 flush_valid_i,
  input logic [IDX_W-1:0]     flush_idx_i,
  input logic [ROB_DEPTH-1:0] fwd_en_o
);

  for (genvar i = 0; i < ROB_DEPTH; i++) begin : g_bit
    localparam logic [IDX_W-1:0] BIDX = IDX_W'(i);
    logic younger;
    assign younger = age_from_head(i, int'(rob_head_i), ROB_DEPTH) >
                     age_from_head(int'(flush_idx_i), int'(rob_head_i), ROB_DEPTH);

    // R5: a load younger than the flush point cannot pulse next cycle
    p_flush_kills_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_valid_i && younger) |=> !fwd_en_o[i]);

    // R2: at-head policy releases only the head entry
    p_head_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_en_o[i] && !$past(mode_i)) |-> ($past(rob_head_i) == BIDX));

    // R6: the enable is a single-cycle pulse
    p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_en_o[i] |=> !fwd_en_o[i]);

    // R6: a freshly allocated entry has not completed, so it cannot pulse two cycles on
    p_fresh_alloc_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_valid_i && alloc_idx_i == BIDX) |-> ##2 !fwd_en_o[i]);
  end

endmodule

bind safe_fwd_gate safe_fwd_gate_chk #(.ROB_DEPTH(ROB_DEPTH), .IDX_W(IDX_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mode_i        (mode_i),
  .rob_head_i    (rob_head_i),
  .alloc_valid_i (alloc_valid_i),
  .alloc_idx_i   (alloc_idx_i),
  .flush_valid_i (flush_valid_i),
  .flush_idx_i   (flush_idx_i),
  .fwd_en_o      (fwd_en_o)
);

// File: tb/sim_safe_fwd_gate.sv
`timescale 1ns/1ps
module sim_safe_fwd_gate;

  localparam int D = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_i = 1'b0;
  logic [3:0] rob_head_i = '0;
  logic alloc_valid_i = 0, alloc_br_i = 0, alloc_mem_i = 0, alloc_ld_i = 0;
  logic [3:0] alloc_idx_i = '0;
  logic br_res_valid_i = 0, agen_valid_i = 0, ld_done_valid_i = 0, flush_valid_i = 0;
  logic [3:0] br_res_idx_i = '0, agen_idx_i = '0, ld_done_idx_i = '0, flush_idx_i = '0;
  logic [D-1:0] fwd_en_o;

  int nchk = 0;
  int nfail = 0;
  bit finished = 0;

  logic [D-1:0] m_trk = '0, m_done = '0, m_ctl = '0, m_adr = '0;

  always #2 clk = ~clk;

  safe_fwd_gate u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .rob_head_i(rob_head_i),
    .alloc_valid_i(alloc_valid_i), .alloc_idx_i(alloc_idx_i), .alloc_br_i(alloc_br_i),
    .alloc_mem_i(alloc_mem_i), .alloc_ld_i(alloc_ld_i),
    .br_res_valid_i(br_res_valid_i), .br_res_idx_i(br_res_idx_i),
    .agen_valid_i(agen_valid_i), .agen_idx_i(agen_idx_i),
    .ld_done_valid_i(ld_done_valid_i), .ld_done_idx_i(ld_done_idx_i),
    .flush_valid_i(flush_valid_i), .flush_idx_i(flush_idx_i),
    .fwd_en_o(fwd_en_o)
  );

  function automatic int age(input int i, input int h);
    return (i - h + D) % D;
  endfunction

  function automatic logic kill_of(input int i);
    return flush_valid_i && age(i, rob_head_i) > age(flush_idx_i, rob_head_i);
  endfunction

  function automatic logic [D-1:0] exp_fire();
    logic [D-1:0] f = '0;
    for (int i = 0; i < D; i++) begin
      logic ok;
      if (mode_i) begin
        ok = 1'b1;
        for (int j = 0; j < D; j++)
          if ((m_ctl[j] || m_adr[j]) && age(j, rob_head_i) < age(i, rob_head_i)) ok = 1'b0;
      end else begin
        ok = (i == rob_head_i);
      end
      f[i] = m_trk[i] && m_done[i] && ok && !kill_of(i);
    end
    return f;
  endfunction

  task automatic model_step(input logic [D-1:0] f);
    m_trk &= ~f; m_done &= ~f;
    if (alloc_valid_i) begin
      m_trk[alloc_idx_i] = alloc_ld_i; m_done[alloc_idx_i] = 1'b0;
      m_ctl[alloc_idx_i] = alloc_br_i; m_adr[alloc_idx_i] = alloc_mem_i | alloc_ld_i;
    end
    if (br_res_valid_i) m_ctl[br_res_idx_i] = 1'b0;
    if (agen_valid_i)   m_adr[agen_idx_i] = 1'b0;
    if (ld_done_valid_i && m_trk[ld_done_idx_i]) m_done[ld_done_idx_i] = 1'b1;
    for (int i = 0; i < D; i++)
      if (kill_of(i)) begin m_trk[i] = 0; m_done[i] = 0; m_ctl[i] = 0; m_adr[i] = 0; end
  endtask

  task automatic clear_pulses();
    alloc_valid_i = 0; alloc_br_i = 0; alloc_mem_i = 0; alloc_ld_i = 0;
    br_res_valid_i = 0; agen_valid_i = 0; ld_done_valid_i = 0; flush_valid_i = 0;
  endtask

  // One clock: expected vector from the model, then compare after the edge.
  task automatic tick(input string tag);
    logic [D-1:0] e;
    e = exp_fire();
    model_step(e);
    @(posedge clk); @(negedge clk);
    nchk++;
    if (fwd_en_o !== e) begin
      nfail++;
      $display("FAIL %s: fwd_en_o actual %h expected %h", tag, fwd_en_o, e);
    end
    clear_pulses();
  endtask

  task automatic chk_bit(input string tag, input int idx, input logic v);
    nchk++;
    if (fwd_en_o[idx] !== v) begin
      nfail++;
      $display("FAIL %s: fwd_en_o[%0d] actual %b expected %b", tag, idx, fwd_en_o[idx], v);
    end
  endtask

  task automatic alloc(input int idx, input logic br, input logic mem, input logic ld);
    alloc_valid_i = 1; alloc_idx_i = 4'(idx); alloc_br_i = br; alloc_mem_i = mem; alloc_ld_i = ld;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      nfail++;
      $display("FAIL R6 watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    nchk++;
    if (fwd_en_o !== '0) begin nfail++; $display("FAIL R1: fwd_en_o actual %h expected 0", fwd_en_o); end
    rst_n = 1'b1;
    repeat (4) tick("R1 after reset");

    // Conservative policy with head wrap (R2, R7)
    mode_i = 0; rob_head_i = 14;
    alloc(14, 1, 0, 0); tick("R2 setup");
    alloc(15, 0, 1, 1); tick("R2 setup");
    alloc(0, 0, 1, 1);  tick("R2 setup");
    ld_done_valid_i = 1; ld_done_idx_i = 15; tick("R2 setup");
    ld_done_valid_i = 1; ld_done_idx_i = 0;  tick("R2 setup");
    br_res_valid_i = 1; br_res_idx_i = 14; agen_valid_i = 1; agen_idx_i = 15; tick("R2 setup");
    agen_valid_i = 1; agen_idx_i = 0; tick("R2 setup");
    tick("R2 not at head"); chk_bit("R2 held off head", 15, 0); chk_bit("R2 held off head", 0, 0);
    rob_head_i = 15; tick("R2 head");  chk_bit("R2 R7 forwards at head", 15, 1);
    tick("R6 pulse");                  chk_bit("R6 single cycle", 15, 0);
    rob_head_i = 0; tick("R7 wrap");   chk_bit("R7 wrapped head", 0, 1);
    tick("R6 idle");

    // Early policy (R3, R4)
    mode_i = 1; rob_head_i = 4;
    alloc(4, 1, 0, 0); tick("R3 setup");
    alloc(5, 0, 1, 0); tick("R3 setup");
    alloc(6, 0, 1, 1); tick("R3 setup");
    ld_done_valid_i = 1; ld_done_idx_i = 6; tick("R3 setup");
    tick("R3"); chk_bit("R3 older branch pending", 6, 0);
    br_res_valid_i = 1; br_res_idx_i = 4; tick("R4 setup");
    tick("R4"); chk_bit("R4 older address pending", 6, 0);
    agen_valid_i = 1; agen_idx_i = 5; tick("R4 setup");
    tick("R4"); chk_bit("R4 released after address", 6, 1);

    // Flush boundary (R5, R9)
    agen_valid_i = 1; agen_idx_i = 6; tick("R5 setup");
    alloc(7, 1, 0, 0); tick("R5 setup");
    alloc(8, 0, 1, 1); tick("R5 setup");
    alloc(9, 0, 1, 1); tick("R5 setup");
    flush_valid_i = 1; flush_idx_i = 8; tick("R5 flush");
    ld_done_valid_i = 1; ld_done_idx_i = 8; tick("R9 setup");
    ld_done_valid_i = 1; ld_done_idx_i = 9; tick("R5 setup");
    agen_valid_i = 1; agen_idx_i = 8; tick("R9 setup");
    br_res_valid_i = 1; br_res_idx_i = 7; tick("R9 setup");
    tick("R9"); chk_bit("R9 flushing entry kept", 8, 1); chk_bit("R5 younger cancelled", 9, 0);
    repeat (3) begin tick("R5"); chk_bit("R5 younger never forwards", 9, 0); end

    // Untracked completion (R8)
    ld_done_valid_i = 1; ld_done_idx_i = 10; tick("R8");
    tick("R8"); chk_bit("R8 untracked completion", 10, 0);

    // Mode switch (R10)
    mode_i = 0;
    alloc(10, 0, 0, 0); tick("R10 setup");
    alloc(11, 0, 1, 1); tick("R10 setup");
    ld_done_valid_i = 1; ld_done_idx_i = 11; tick("R10 setup");
    tick("R10"); chk_bit("R10 held at-head", 11, 0);
    mode_i = 1; tick("R10"); chk_bit("R10 released on switch", 11, 1);

    // Constrained random traffic against the model (R2..R9)
    begin
      int hd = 4, tl = 12;
      for (int c = 0; c < 4000; c++) begin
        int cnt = (tl - hd + D) % D;
        if ($urandom % 16 == 0) mode_i = ~mode_i;
        rob_head_i = 4'(hd);
        if (cnt < 15 && $urandom % 2 == 0) begin
          int k = $urandom % 4;
          alloc(tl, k == 1, k >= 2, k == 3);
          tl = (tl + 1) % D;
        end
        if (cnt > 0) begin
          if ($urandom % 3 == 0) begin br_res_valid_i = 1; br_res_idx_i = 4'((hd + $urandom % cnt) % D); end
          if ($urandom % 3 == 0) begin agen_valid_i = 1; agen_idx_i = 4'((hd + $urandom % cnt) % D); end
          if ($urandom % 2 == 0) begin ld_done_valid_i = 1; ld_done_idx_i = 4'((hd + $urandom % cnt) % D); end
          if ($urandom % 24 == 0) begin
            int f = (hd + $urandom % cnt) % D;
            flush_valid_i = 1; flush_idx_i = 4'(f);
            tl = (f + 1) % D;
          end
        end
        tick("R6 random vs model");
        if (((tl - hd + D) % D) > 0 && $urandom % 4 == 0) hd = (hd + 1) % D;
      end
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

endmodule